// File: doc/BRIEF.md
# MMU Access Check and Fault Encoder

This block judges one memory access per cycle against the result of a single translation lookup. It takes a 32-bit virtual address, an access kind (data load, data store or instruction fetch) and the processor privilege bit. It also takes the hit, protection, dirty, page-number and page-size fields from a lookup done elsewhere. From these it forms a registered verdict: a 4-bit status, the physical address, the granted read or write right and the exception vector that a fault raises.

Three address paths are recognised. In user mode, the upper half of the space is closed except for a small window. In privileged mode, a fixed segment maps straight through with its top three bits cleared. Every other access goes through the lookup result, and the protection rule there depends on both the page protection field and the privilege bit. A combinational `use_asid` output tells the lookup whether to compare address-space identifiers.

Top module: `mmu_access_check`

## Requirements
- R1: A request on `req_valid` gives `res_valid` high exactly one cycle later. A cycle without a request gives `res_valid` low one cycle later, and synchronous `rst` clears `res_valid`.
- R2: On a hit, the protection index is {`tlb_prot`, `priv`} (3 bits). For a data access, index 0 or 2 is a violation: status 6 (write violation) for a store (`acc_type`=1) and status 5 (read violation) for a load (`acc_type`=0).
- R3: Index 1, 4 or 5 allows loads only (status 0, `res_rd`=1). A store gets status 6.
- R4: Index 3, 6 or 7 gives status 0, with `res_wr`=1 for a store and `res_rd`=1 for a load, when the page is dirty.
- R5: On a hit, `res_paddr` = ({`tlb_ppn`,10'b0} with the bits below the page size cleared) OR (`vaddr` bits below the page size). The page size code `tlb_pgsz` is 0=1 KB, 1=4 KB, 2=64 KB, 3=1 MB.
- R6: A store that is otherwise allowed, to a page whose `tlb_dirty` is 0, gets status 7 (first write) with no grant. A load from such a page is allowed.
- R7: On a miss, a load gets status 3, a store status 4 and a fetch (`acc_type`=2) status 1.
- R8: A fetch hit with index 0 or 2 gets status 2 (fetch violation). Any other index gives status 0 with `res_rd`=1.
- R9: With `priv`=0, an address at or above 0x8000_0000 outside 0xE000_0000..0xE400_0000 (both ends allowed) is an address error. The status is 9 for a load, 10 for a store and 8 for a fetch. Addresses inside the window go to the lookup.
- R10: With `priv`=1, addresses from 0x8000_0000 up to but not including 0xC000_0000 ignore the lookup. They give status 0 with `res_paddr` = `vaddr` with bits 31:29 cleared, and grant the right that matches the access.
- R11: `res_vec` is 0x000 for status 0 and 0x040 for status 1 or 3. It is 0x060 for status 4, 0x080 for status 7, 0x0A0 for status 2 or 5, 0x0C0 for status 6, 8 or 9, and 0x100 for status 10.
- R12: `use_asid` is 0 only when `priv`=1 and `asid_bypass_en`=1.
- R13: Any nonzero status grants neither `res_rd` nor `res_wr`, and the two grants are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request strobe |
| vaddr | input | 32 | Virtual address |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch |
| priv | input | 1 | Privileged mode |
| asid_bypass_en | input | 1 | Privileged accesses skip the ASID compare |
| tlb_hit | input | 1 | Lookup found an entry |
| tlb_prot | input | 2 | Page protection field |
| tlb_dirty | input | 1 | Page already written |
| tlb_ppn | input | 22 | Physical page number |
| tlb_pgsz | input | 2 | Page size code |
| use_asid | output | 1 | Lookup should compare ASID |
| res_valid | output | 1 | Result strobe |
| res_code | output | 4 | Status, 0 = OK |
| res_paddr | output | 32 | Physical address |
| res_rd | output | 1 | Read granted |
| res_wr | output | 1 | Write granted |
| res_vec | output | 12 | Exception vector |

## Verification
The protection decoder is driven with all eight indices under loads, stores and fetches. This separates read-only from read-write pages and the data rule from the fetch rule. Stores are also repeated on clean pages to tell a first-write fault from a protection fault. One offset and page number are run through all four page sizes, so a wrong mask width changes the address. The edges of the user window and the privileged bypass segment show which path each boundary address takes.

// File: rtl/mmu_access_check.sv
module mmu_access_check #(
  parameter int PPN_W = 22,
  parameter int VEC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [31:0]      vaddr,
  input  logic [1:0]       acc_type,
  input  logic             priv,
  input  logic             asid_bypass_en,
  input  logic             tlb_hit,
  input  logic [1:0]       tlb_prot,
  input  logic             tlb_dirty,
  input  logic [PPN_W-1:0] tlb_ppn,
  input  logic [1:0]       tlb_pgsz,
  output logic             use_asid,
  output logic             res_valid,
  output logic [3:0]       res_code,
  output logic [31:0]      res_paddr,
  output logic             res_rd,
  output logic             res_wr,
  output logic [VEC_W-1:0] res_vec
);
  localparam int PG_LSB = 32 - PPN_W;
  localparam logic [31:0] WIN_LO = 32'hE000_0000;
  localparam logic [31:0] WIN_HI = 32'hE400_0000;

  localparam logic [3:0] ST_OK = 4'd0, ST_IMISS = 4'd1, ST_IVIOL = 4'd2,
    ST_DMISS_R = 4'd3, ST_DMISS_W = 4'd4, ST_DVIOL_R = 4'd5, ST_DVIOL_W = 4'd6,
    ST_FIRSTW = 4'd7, ST_IADDR = 4'd8, ST_DADDR_R = 4'd9, ST_DADDR_W = 4'd10;

  wire is_st = acc_type == 2'd1;
  wire is_if = acc_type == 2'd2;
  wire [2:0] pidx = {tlb_prot, priv};
  wire no_acc = pidx == 3'd0 || pidx == 3'd2;
  wire rw_pg = pidx == 3'd3 || pidx == 3'd6 || pidx == 3'd7;
  wire in_win = vaddr >= WIN_LO && vaddr <= WIN_HI;
  wire usr_err = !priv && vaddr[31] && !in_win;
  wire bypass = priv && vaddr[31:30] == 2'b10;

  assign use_asid = !(priv && asid_bypass_en);

  logic [4:0]  pg_sh;
  logic [31:0] off_m, pa_tlb, pa_n;
  logic [3:0]  code_n;
  logic        rd_n, wr_n;
  logic [VEC_W-1:0] vec_n;

  always_comb begin
    case (tlb_pgsz)
      2'd0:    pg_sh = 5'd10;
      2'd1:    pg_sh = 5'd12;
      2'd2:    pg_sh = 5'd16;
      default: pg_sh = 5'd20;
    endcase
    off_m  = (32'd1 << pg_sh) - 32'd1;
    pa_tlb = ({tlb_ppn, {PG_LSB{1'b0}}} & ~off_m) | (vaddr & off_m);
  end

  always_comb begin
    code_n = ST_OK;
    pa_n   = '0;
    rd_n   = 1'b0;
    wr_n   = 1'b0;
    if (usr_err) begin
      code_n = is_if ? ST_IADDR : (is_st ? ST_DADDR_W : ST_DADDR_R);
    end else if (bypass) begin
      pa_n = {3'b000, vaddr[28:0]};
      rd_n = !is_st;
      wr_n = is_st;
    end else if (!tlb_hit) begin
      code_n = is_if ? ST_IMISS : (is_st ? ST_DMISS_W : ST_DMISS_R);
    end else begin
      pa_n = pa_tlb;
      if (is_if) begin
        if (no_acc) code_n = ST_IVIOL;
        else rd_n = 1'b1;
      end else if (no_acc) begin
        code_n = is_st ? ST_DVIOL_W : ST_DVIOL_R;
      end else if (is_st && !rw_pg) begin
        code_n = ST_DVIOL_W;
      end else if (is_st && !tlb_dirty) begin
        code_n = ST_FIRSTW;
      end else begin
        rd_n = !is_st;
        wr_n = is_st;
      end
    end
  end

  always_comb begin
    case (code_n)
      ST_IMISS, ST_DMISS_R:           vec_n = VEC_W'(12'h040);
      ST_DMISS_W:                     vec_n = VEC_W'(12'h060);
      ST_FIRSTW:                      vec_n = VEC_W'(12'h080);
      ST_IVIOL, ST_DVIOL_R:           vec_n = VEC_W'(12'h0A0);
      ST_DVIOL_W, ST_IADDR, ST_DADDR_R: vec_n = VEC_W'(12'h0C0);
      ST_DADDR_W:                     vec_n = VEC_W'(12'h100);
      default:                        vec_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) res_valid <= 1'b0;
    else     res_valid <= req_valid;
    res_code  <= code_n;
    res_paddr <= pa_n;
    res_rd    <= rd_n;
    res_wr    <= wr_n;
    res_vec   <= vec_n;
  end
endmodule

// File: rtl/mmu_access_check_sva.sv
module mmu_access_check_sva #(
  parameter int PPN_W = 22,
  parameter int VEC_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [31:0]      vaddr,
  input logic [1:0]       acc_type,
  input logic             priv,
  input logic             res_valid,
  input logic [3:0]       res_code,
  input logic [31:0]      res_paddr,
  input logic             res_rd,
  input logic             res_wr,
  input logic [VEC_W-1:0] res_vec
);
  // R1
  req_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  // R1
  idle_to_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  // R11
  ok_no_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code == 4'd0) |-> res_vec == '0);
  // R13
  fault_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_code != 4'd0) |-> (!res_rd && !res_wr));
  // R13
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !(res_rd && res_wr));
  // R10
  bypass_seg_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && priv && vaddr[31:30] == 2'b10) |=>
      (res_code == 4'd0 && res_paddr[31:29] == 3'b000));
  // R9
  user_high_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !priv && vaddr[31:28] >= 4'h8 && vaddr[31:28] <= 4'hD) |=>
      (res_code >= 4'd8 && res_code <= 4'd10));
endmodule

bind mmu_access_check mmu_access_check_sva #(.PPN_W(PPN_W), .VEC_W(VEC_W)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr),
  .acc_type(acc_type), .priv(priv), .res_valid(res_valid),
  .res_code(res_code), .res_paddr(res_paddr), .res_rd(res_rd),
  .res_wr(res_wr), .res_vec(res_vec)
);

// File: tb/test_mmu_access_check.sv
`timescale 1ns/1ps
module test_mmu_access_check;
  logic clk = 1'b0, rst = 1'b1, req_valid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  acc_type = '0, tlb_prot = '0, tlb_pgsz = '0;
  logic priv = 1'b0, asid_bypass_en = 1'b0, tlb_hit = 1'b0, tlb_dirty = 1'b0;
  logic [21:0] tlb_ppn = '0;
  logic use_asid, res_valid, res_rd, res_wr;
  logic [3:0]  res_code;
  logic [31:0] res_paddr;
  logic [11:0] res_vec;
  int n_chk = 0, n_bad = 0;

  mmu_access_check i_mmu_access_check (.*);

  always #5 clk = ~clk;

  task automatic apply(input logic [31:0] va, input logic [1:0] ty, input logic md,
                       input logic hit, input logic [1:0] pr, input logic dty,
                       input logic [21:0] ppn, input logic [1:0] sz);
    vaddr = va; acc_type = ty; priv = md; tlb_hit = hit; tlb_prot = pr;
    tlb_dirty = dty; tlb_ppn = ppn; tlb_pgsz = sz; req_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic expect_res(input string tag, input logic [3:0] code, input logic [11:0] vec,
                            input logic rd, input logic wr, input logic chk_pa,
                            input logic [31:0] pa);
    n_chk++;
    if (res_valid !== 1'b1 || res_code !== code || res_vec !== vec ||
        res_rd !== rd || res_wr !== wr || (chk_pa && res_paddr !== pa)) begin
      n_bad++;
      $display("FAIL %s: got v=%b code=%0d vec=%h rd=%b wr=%b pa=%h, want v=1 code=%0d vec=%h rd=%b wr=%b pa=%h",
               tag, res_valid, res_code, res_vec, res_rd, res_wr, res_paddr, code, vec, rd, wr, pa);
    end
  endtask

  task automatic t_reset();
    n_chk++;
    if (res_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: res_valid=%b expected 0", res_valid);
    end
  endtask

  task automatic t_idle();
    req_valid = 1'b0;
    @(negedge clk);
    n_chk++;
    if (res_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 idle: res_valid=%b expected 0", res_valid);
    end
  endtask

  task automatic t_bypass();
    apply(32'h9234_5678, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, '0, 2'd0);
    expect_res("R10 bypass load", 4'd0, 12'h000, 1, 0, 1, 32'h1234_5678);
    apply(32'hA000_0004, 2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 22'h3FFFFF, 2'd0);
    expect_res("R10 bypass store, lookup ignored", 4'd0, 12'h000, 0, 1, 1, 32'h0000_0004);
    apply(32'hBFFF_FFFC, 2'd2, 1'b1, 1'b0, 2'd0, 1'b0, '0, 2'd0);
    expect_res("R10 bypass top fetch", 4'd0, 12'h000, 1, 0, 1, 32'h1FFF_FFFC);
    apply(32'hC000_0000, 2'd0, 1'b1, 1'b0, 2'd0, 1'b0, '0, 2'd0);
    expect_res("R10 above segment uses lookup", 4'd3, 12'h040, 0, 0, 0, 0);
  endtask

  task automatic t_user_err();
    apply(32'h8000_0000, 2'd0, 1'b0, 1'b1, 2'd3, 1'b1, '0, 2'd0);
    expect_res("R9 load error", 4'd9, 12'h0C0, 0, 0, 0, 0);
    apply(32'hC000_1000, 2'd1, 1'b0, 1'b1, 2'd3, 1'b1, '0, 2'd0);
    expect_res("R9 store error", 4'd10, 12'h100, 0, 0, 0, 0);
    apply(32'hDFFF_FFFF, 2'd2, 1'b0, 1'b1, 2'd3, 1'b1, '0, 2'd0);
    expect_res("R9 fetch error", 4'd8, 12'h0C0, 0, 0, 0, 0);
    apply(32'hE400_0000, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, '0, 2'd0);
    expect_res("R9 window top passes", 4'd3, 12'h040, 0, 0, 0, 0);
    apply(32'hE000_0000, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0, '0, 2'd0);
    expect_res("R9 window bottom passes", 4'd4, 12'h060, 0, 0, 0, 0);
    apply(32'hE400_0004, 2'd1, 1'b0, 1'b0, 2'd0, 1'b0, '0, 2'd0);
    expect_res("R9 above window", 4'd10, 12'h100, 0, 0, 0, 0);
  endtask

  task automatic t_miss();
    apply(32'h0000_1000, 2'd0, 1'b0, 1'b0, 2'd3, 1'b1, '0, 2'd1);
    expect_res("R7 load miss", 4'd3, 12'h040, 0, 0, 0, 0);
    apply(32'h0000_1000, 2'd1, 1'b0, 1'b0, 2'd3, 1'b1, '0, 2'd1);
    expect_res("R7 store miss", 4'd4, 12'h060, 0, 0, 0, 0);
    apply(32'h0000_1000, 2'd2, 1'b1, 1'b0, 2'd3, 1'b1, '0, 2'd1);
    expect_res("R7 fetch miss", 4'd1, 12'h040, 0, 0, 0, 0);
  endtask

  task automatic t_prot();
    // index = {pr, md}
    apply(32'h3A5C, 2'd0, 1'b0, 1'b1, 2'd0, 1'b1, 22'h0ABF, 2'd1);
    expect_res("R2 idx0 load", 4'd5, 12'h0A0, 0, 0, 0, 0);
    apply(32'h3A5C, 2'd1, 1'b0, 1'b1, 2'd0, 1'b1, 22'h0ABF, 2'd1);
    expect_res("R2 idx0 store", 4'd6, 12'h0C0, 0, 0, 0, 0);
    apply(32'h3A5C, 2'd0, 1'b0, 1'b1, 2'd1, 1'b1, 22'h0ABF, 2'd1);
    expect_res("R2 idx2 load", 4'd5, 12'h0A0, 0, 0, 0, 0);
    apply(32'h3A5C, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1, 22'h0ABF, 2'd1);
    expect_res("R3 idx1 load", 4'd0, 12'h000, 1, 0, 1, 32'h002A_FA5C);
    apply(32'h3A5C, 2'd1, 1'b1, 1'b1, 2'd0, 1'b1, 22'h0ABF, 2'd1);
    expect_res("R3 idx1 store", 4'd6, 12'h0C0, 0, 0, 0, 0);
    apply(32'h3A5C, 2'd1, 1'b0, 1'b1, 2'd2, 1'b1, 22'h0ABF, 2'd1);
    expect_res("R3 idx4 store", 4'd6, 12'h0C0, 0, 0, 0, 0);
    apply(32'h3A5C, 2'd0, 1'b1, 1'b1, 2'd2, 1'b1, 22'h0ABF, 2'd1);
    expect_res("R3 idx5 load", 4'd0, 12'h000, 1, 0, 1, 32'h002A_FA5C);
    apply(32'h3A5C, 2'd1, 1'b1, 1'b1, 2'd1, 1'b1, 22'h0ABF, 2'd1);
    expect_res("R4 idx3 store", 4'd0, 12'h000, 0, 1, 1, 32'h002A_FA5C);
    apply(32'h3A5C, 2'd1, 1'b0, 1'b1, 2'd3, 1'b1, 22'h0ABF, 2'd1);
    expect_res("R4 idx6 store", 4'd0, 12'h000, 0, 1, 1, 32'h002A_FA5C);
    apply(32'h3A5C, 2'd0, 1'b1, 1'b1, 2'd3, 1'b1, 22'h0ABF, 2'd1);
    expect_res("R4 idx7 load", 4'd0, 12'h000, 1, 0, 1, 32'h002A_FA5C);
  endtask

  task automatic t_pgsz();
    apply(32'h3A5C, 2'd0, 1'b0, 1'b1, 2'd3, 1'b1, 22'h0ABF, 2'd0);
    expect_res("R5 1KB page", 4'd0, 12'h000, 1, 0, 1, 32'h002A_FE5C);
    apply(32'h3A5C, 2'd0, 1'b0, 1'b1, 2'd3, 1'b1, 22'h0ABF, 2'd2);
    expect_res("R5 64KB page", 4'd0, 12'h000, 1, 0, 1, 32'h002A_3A5C);
    apply(32'h3A5C, 2'd0, 1'b0, 1'b1, 2'd3, 1'b1, 22'h0ABF, 2'd3);
    expect_res("R5 1MB page", 4'd0, 12'h000, 1, 0, 1, 32'h0020_3A5C);
  endtask

  task automatic t_firstw();
    apply(32'h3A5C, 2'd1, 1'b0, 1'b1, 2'd3, 1'b0, 22'h0ABF, 2'd1);
    expect_res("R6 clean store", 4'd7, 12'h080, 0, 0, 0, 0);
    apply(32'h3A5C, 2'd0, 1'b0, 1'b1, 2'd3, 1'b0, 22'h0ABF, 2'd1);
    expect_res("R6 clean load", 4'd0, 12'h000, 1, 0, 1, 32'h002A_FA5C);
    apply(32'h3A5C, 2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 22'h0ABF, 2'd1);
    expect_res("R6 read-only clean store is violation", 4'd6, 12'h0C0, 0, 0, 0, 0);
  endtask

  task automatic t_fetch();
    apply(32'h3A5C, 2'd2, 1'b0, 1'b1, 2'd0, 1'b0, 22'h0ABF, 2'd1);
    expect_res("R8 fetch idx0", 4'd2, 12'h0A0, 0, 0, 0, 0);
    apply(32'h3A5C, 2'd2, 1'b0, 1'b1, 2'd2, 1'b0, 22'h0ABF, 2'd1);
    expect_res("R8 fetch idx4", 4'd0, 12'h000, 1, 0, 1, 32'h002A_FA5C);
    apply(32'h3A5C, 2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 22'h0ABF, 2'd1);
    expect_res("R8 fetch idx1", 4'd0, 12'h000, 1, 0, 1, 32'h002A_FA5C);
  endtask

  task automatic chk_asid(input logic md, input logic en, input logic want);
    priv = md; asid_bypass_en = en;
    #1;
    n_chk++;
    if (use_asid !== want) begin
      n_bad++;
      $display("FAIL R12 priv=%b en=%b: use_asid=%b expected %b", md, en, use_asid, want);
    end
  endtask

  task automatic t_asid();
    chk_asid(1'b1, 1'b1, 1'b0);
    chk_asid(1'b0, 1'b1, 1'b1);
    chk_asid(1'b1, 1'b0, 1'b1);
    chk_asid(1'b0, 1'b0, 1'b1);
    asid_bypass_en = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_idle();
    t_bypass();
    t_user_err();
    t_miss();
    t_prot();
    t_pgsz();
    t_firstw();
    t_fetch();
    t_idle();
    t_asid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule